// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the signals of a rotary position encoder into a 32-bit signed position count. Two channel inputs carry either a quadrature pair or a count-frequency and direction pair. A zero-marker input and a strobe input capture the count into two latch registers. Each of the four pins passes through a two-flop synchronizer and then through a glitch filter of programmable length. All logic runs on one system clock.

A small register port sets the input mode, the latch edge policy and the reset policy. It also holds the maximum count and the filter length, and lets software load the count. The count can wrap freely modulo 2^32. It can also be cleared by every zero marker, cleared by only the first marker after arming, or wrapped at a programmed maximum. An illegal quadrature transition sets a sticky error bit. The error bit drives the interrupt output.

Top module: `qenc_counter`

Register map (3-bit address): 0 control, 1 maximum count, 2 filter length, 3 count, 4 zero latch, 5 strobe latch, 6 status. A read returns the addressed register. Unused addresses read zero. Control fields are: bit0 input mode, bit1 zero-latch edge mode, bit2 strobe-latch edge mode, bits[4:3] reset policy.

## Requirements
- R1: In quadrature mode (control bit0 = 0), each single-channel step of the forward sequence (A,B) 00→10→11→01→00 adds one to the count. Each step of the reverse sequence subtracts one. Under the free policy (bits[4:3] = 00) the count wraps modulo 2^32, so 0xFFFFFFFF plus one gives 0.
- R2: In frequency/direction mode (control bit0 = 1), each rising edge of A counts up when B = 1 and down when B = 0. A falling edge of A and any change of B leave the count unchanged.
- R3: With filter length N (register 2, 8 bits), a pin change reaches the decoder only after it has held for N consecutive clocks after synchronization. A shorter pulse is discarded. N = 0 behaves as N = 1.
- R4: A zero-marker event copies the count into the zero latch (address 4). A strobe event copies it into the strobe latch (address 5). Neither event changes the count under the free policy.
- R5: With an edge-mode bit at 0, the corresponding latch triggers on a rising edge only. With the bit at 1, it triggers on a rising edge when the last count step was forward, and on a falling edge when the last step was reverse. Bit1 controls the zero latch and bit2 controls the strobe latch.
- R6: Under the marker policy (bits[4:3] = 01), every zero-marker event clears the count to 0. The zero latch receives the value from before the clear.
- R7: Under the single-marker policy (bits[4:3] = 10), any control write arms the block. The first zero-marker event after arming clears the count. Later events still latch but do not clear.
- R8: Under the wrap policy (bits[4:3] = 11), counting up from the maximum count (address 1) gives 0, and counting down from 0 gives the maximum count. Zero markers do not clear the count.
- R9: In quadrature mode, A and B changing in the same cycle is a count error. The count is left unchanged, status bit0 (address 6) is set and stays set, and err_irq is high while the bit is set. Writing 1 to status bit0 clears it. Frequency/direction mode never flags an error.
- R10: After reset the count, both latches, the status bit and err_irq are 0. The control and filter registers are also 0.
- R11: A write to address 3 loads the count. It takes priority over a step or a marker clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_a | input | 1 | Channel A, or the count-frequency input |
| ch_b | input | 1 | Channel B, or the direction input |
| zmark | input | 1 | Zero-marker input |
| strobe | input | 1 | Strobe input |
| wr_en | input | 1 | Register write enable |
| addr | input | 3 | Register address for reads and writes |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Read data of the addressed register |
| count | output | 32 | Current position count |
| zero_latch | output | 32 | Count captured on a zero-marker event |
| strobe_latch | output | 32 | Count captured on a strobe event |
| err_irq | output | 1 | Count-error interrupt, high while the sticky error bit is set |

## Verification
The bench walks full forward and reverse quadrature cycles, including a reversal mid-cycle. A decoder that picked direction from the wrong channel would count the wrong way there. It drives both channels in one cycle and expects the count to hold and the sticky error to set. It checks that clearing the error needs an explicit write, which catches designs that count on a double change or drop the error bit by themselves. Directed cases cover several boundaries:
- the 2^32 wrap;
- wrapping down from zero to the programmed maximum;
- a marker that must latch the value from before the clear;
- a second marker in single-marker mode that must not clear;
- a reverse-direction latch that must ignore the rising edge;
- a short glitch that a filter with too short a length would pass.

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int CNT_W  = 32,
  parameter int FILT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_a,
  input  logic             ch_b,
  input  logic             zmark,
  input  logic             strobe,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] zero_latch,
  output logic [CNT_W-1:0] strobe_latch,
  output logic             err_irq
);

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_MAX  = 3'd1;
  localparam logic [2:0] A_FILT = 3'd2;
  localparam logic [2:0] A_CNT  = 3'd3;
  localparam logic [2:0] A_ZL   = 3'd4;
  localparam logic [2:0] A_SL   = 3'd5;
  localparam logic [2:0] A_STAT = 3'd6;

  localparam logic [1:0] POL_FREE = 2'd0;
  localparam logic [1:0] POL_MRK  = 2'd1;
  localparam logic [1:0] POL_ONE  = 2'd2;
  localparam logic [1:0] POL_WRAP = 2'd3;

  localparam int NPIN = 4;

  logic [4:0]        ctrl_q;
  logic [CNT_W-1:0]  max_q;
  logic [FILT_W-1:0] flen_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              err_q;
  logic              armed_q;
  logic              dir_fwd_q;

  logic [NPIN-1:0]   s1_q, s2_q, flt_q, pf_q;
  logic [FILT_W-1:0] fcnt_q [NPIN];

  wire       mode_fd = ctrl_q[0];
  wire       zmode   = ctrl_q[1];
  wire       smode   = ctrl_q[2];
  wire [1:0] pol     = ctrl_q[4:3];

  wire wr_ctrl = wr_en && addr == A_CTRL;
  wire wr_cnt  = wr_en && addr == A_CNT;
  wire wr_clr  = wr_en && addr == A_STAT && wr_data[0];

  // synchronizer and per-pin glitch filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      flt_q <= '0;
      pf_q  <= '0;
      for (int i = 0; i < NPIN; i++) fcnt_q[i] <= '0;
    end else begin
      s1_q <= {strobe, zmark, ch_b, ch_a};
      s2_q <= s1_q;
      pf_q <= flt_q;
      for (int i = 0; i < NPIN; i++) begin
        if (s2_q[i] == flt_q[i])
          fcnt_q[i] <= '0;
        else if ({1'b0, fcnt_q[i]} + 1'b1 >= {1'b0, flen_q}) begin
          flt_q[i]  <= s2_q[i];
          fcnt_q[i] <= '0;
        end else
          fcnt_q[i] <= fcnt_q[i] + 1'b1;
      end
    end
  end

  wire a  = flt_q[0];
  wire b  = flt_q[1];
  wire da = a ^ pf_q[0];
  wire db = b ^ pf_q[1];

  wire q_err  = !mode_fd && da && db;
  wire step   = mode_fd ? (a && !pf_q[0]) : (da ^ db);
  wire up     = mode_fd ? b : (a ^ pf_q[1]);

  wire z_rise = flt_q[2] && !pf_q[2];
  wire z_fall = !flt_q[2] && pf_q[2];
  wire s_rise = flt_q[3] && !pf_q[3];
  wire s_fall = !flt_q[3] && pf_q[3];
  wire z_evt  = zmode ? (dir_fwd_q ? z_rise : z_fall) : z_rise;
  wire s_evt  = smode ? (dir_fwd_q ? s_rise : s_fall) : s_rise;

  wire mrk_clr = z_evt && (pol == POL_MRK || (pol == POL_ONE && armed_q));

  logic [CNT_W-1:0] cnt_step;
  always_comb begin
    if (pol == POL_WRAP)
      cnt_step = up ? ((cnt_q == max_q) ? '0 : cnt_q + 1'b1)
                    : ((cnt_q == '0) ? max_q : cnt_q - 1'b1);
    else
      cnt_step = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      max_q        <= '0;
      flen_q       <= '0;
      cnt_q        <= '0;
      zero_latch   <= '0;
      strobe_latch <= '0;
      err_q        <= 1'b0;
      armed_q      <= 1'b0;
      dir_fwd_q    <= 1'b1;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data[4:0];
      if (wr_en && addr == A_MAX)  max_q  <= wr_data;
      if (wr_en && addr == A_FILT) flen_q <= wr_data[FILT_W-1:0];

      if (wr_cnt)       cnt_q <= wr_data;
      else if (mrk_clr) cnt_q <= '0;
      else if (step)    cnt_q <= cnt_step;

      if (step) dir_fwd_q <= up;

      if (wr_ctrl)                      armed_q <= 1'b1;
      else if (pol == POL_ONE && z_evt) armed_q <= 1'b0;

      if (z_evt) zero_latch   <= cnt_q;
      if (s_evt) strobe_latch <= cnt_q;

      if (q_err)       err_q <= 1'b1;
      else if (wr_clr) err_q <= 1'b0;
    end
  end

  assign count   = cnt_q;
  assign err_irq = err_q;

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = {{(CNT_W-5){1'b0}}, ctrl_q};
      A_MAX:   rd_data = max_q;
      A_FILT:  rd_data = {{(CNT_W-FILT_W){1'b0}}, flen_q};
      A_CNT:   rd_data = cnt_q;
      A_ZL:    rd_data = zero_latch;
      A_SL:    rd_data = strobe_latch;
      A_STAT:  rd_data = {{(CNT_W-1){1'b0}}, err_q};
      default: rd_data = '0;
    endcase
  end

  AST_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_FREE && !wr_cnt) |=>
      (count == $past(count) || count == $past(count) + 1'b1 || count == $past(count) - 1'b1)); // R1
  AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    q_err |=> err_irq); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !wr_clr) |=> err_irq); // R9
  AST_ERR_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (q_err && !wr_cnt && !mrk_clr) |=> $stable(count)); // R9
  AST_ZLATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    z_evt |=> zero_latch == $past(count)); // R4
  AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_WRAP && step && up && cnt_q == max_q && !wr_cnt) |=> count == '0); // R8
  AST_SINGLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !wr_ctrl) |=> !armed_q); // R7

endmodule

// File: tb/test_qenc_counter.sv
module test_qenc_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ch_a = 1'b0, ch_b = 1'b0, zmark = 1'b0, strobe = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, count, zero_latch, strobe_latch;
  logic        err_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  qenc_counter i_qenc_counter (
    .clk(clk), .rst_n(rst_n), .ch_a(ch_a), .ch_b(ch_b), .zmark(zmark),
    .strobe(strobe), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .count(count), .zero_latch(zero_latch),
    .strobe_latch(strobe_latch), .err_irq(err_irq)
  );

  // {A, B, expected count} for a quadrature walk starting at (0,0), count 0
  localparam logic [33:0] QV [13] = '{
    {2'b10, 32'd1}, {2'b11, 32'd2}, {2'b01, 32'd3}, {2'b00, 32'd4},
    {2'b01, 32'd3}, {2'b11, 32'd2}, {2'b10, 32'd1}, {2'b00, 32'd0},
    {2'b01, 32'hFFFF_FFFF}, {2'b11, 32'hFFFF_FFFE}, {2'b10, 32'hFFFF_FFFD},
    {2'b00, 32'hFFFF_FFFC}, {2'b10, 32'hFFFF_FFFD}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] ad, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ad; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 3'd0; wr_data = '0;
  endtask

  task automatic rreg(input logic [2:0] ad, output logic [31:0] d);
    @(negedge clk);
    addr = ad;
    #1 d = rd_data;
  endtask

  task automatic set_ab(input logic na, input logic nb, input int w);
    @(negedge clk);
    ch_a = na; ch_b = nb;
    wait_cyc(w);
  endtask

  task automatic pulse_z;
    @(negedge clk); zmark = 1'b1; wait_cyc(8);
    zmark = 1'b0; wait_cyc(8);
  endtask

  logic [31:0] rv;

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    check("R10 count", count, 32'd0);
    check("R10 zero_latch", zero_latch, 32'd0);
    check("R10 strobe_latch", strobe_latch, 32'd0);
    check("R10 err_irq", {31'd0, err_irq}, 32'd0);
    rreg(3'd6, rv); check("R10 status", rv, 32'd0);
    rreg(3'd0, rv); check("R10 ctrl", rv, 32'd0);

    for (int i = 0; i < 13; i++) begin
      set_ab(QV[i][33], QV[i][32], 8);
      check("R1 quadrature walk", count, QV[i][31:0]);
    end
    // state (1,0)
    wreg(3'd3, 32'hFFFF_FFFF);
    check("R11 count load", count, 32'hFFFF_FFFF);
    set_ab(1'b1, 1'b1, 8);
    check("R1 modulo wrap", count, 32'd0);

    set_ab(1'b0, 1'b0, 8);
    check("R9 count held on error", count, 32'd0);
    check("R9 irq set", {31'd0, err_irq}, 32'd1);
    wait_cyc(10);
    rreg(3'd6, rv); check("R9 status sticky", rv, 32'd1);
    wreg(3'd6, 32'd1);
    check("R9 status cleared", {31'd0, err_irq}, 32'd0);

    wreg(3'd0, 32'h08);
    set_ab(1'b1, 1'b0, 8); set_ab(1'b1, 1'b1, 8);
    check("R6 pre-marker count", count, 32'd2);
    pulse_z;
    check("R6 latch before clear", zero_latch, 32'd2);
    check("R6 marker clears", count, 32'd0);

    set_ab(1'b0, 1'b1, 8);
    @(negedge clk); strobe = 1'b1; wait_cyc(8);
    strobe = 1'b0; wait_cyc(8);
    check("R4 strobe latch", strobe_latch, 32'd1);
    check("R4 strobe leaves count", count, 32'd1);

    wreg(3'd0, 32'h10);
    set_ab(1'b0, 1'b0, 8);
    check("R7 count before first marker", count, 32'd2);
    pulse_z;
    check("R7 first marker clears", count, 32'd0);
    set_ab(1'b1, 1'b0, 8); set_ab(1'b1, 1'b1, 8); set_ab(1'b0, 1'b1, 8);
    pulse_z;
    check("R7 second marker no clear", count, 32'd3);
    check("R7 second marker latches", zero_latch, 32'd3);

    wreg(3'd0, 32'h02);
    set_ab(1'b1, 1'b1, 8); set_ab(1'b1, 1'b0, 8);
    check("R5 reverse count", count, 32'd1);
    @(negedge clk); zmark = 1'b1; wait_cyc(8);
    check("R5 rising ignored in reverse", zero_latch, 32'd3);
    zmark = 1'b0; wait_cyc(8);
    check("R5 falling latches in reverse", zero_latch, 32'd1);

    wreg(3'd1, 32'd5);
    wreg(3'd0, 32'h18);
    wreg(3'd3, 32'd0);
    set_ab(1'b0, 1'b0, 8);
    check("R8 down from zero", count, 32'd5);
    set_ab(1'b1, 1'b0, 8);
    check("R8 up from max", count, 32'd0);
    set_ab(1'b1, 1'b1, 8);
    pulse_z;
    check("R8 marker no clear", count, 32'd1);

    wreg(3'd0, 32'h01);
    wreg(3'd3, 32'd0);
    set_ab(1'b0, 1'b1, 8);
    check("R2 falling A no count", count, 32'd0);
    set_ab(1'b1, 1'b1, 8);
    check("R2 rising A up", count, 32'd1);
    set_ab(1'b0, 1'b1, 8); set_ab(1'b0, 1'b0, 8);
    check("R2 B change no count", count, 32'd1);
    set_ab(1'b1, 1'b0, 8); set_ab(1'b0, 1'b0, 8); set_ab(1'b1, 1'b0, 8);
    check("R2 rising A down", count, 32'hFFFF_FFFF);
    set_ab(1'b0, 1'b1, 8);
    rreg(3'd6, rv); check("R9 no error in freq mode", rv, 32'd0);

    wreg(3'd2, 32'd8);
    set_ab(1'b1, 1'b1, 4);
    set_ab(1'b0, 1'b1, 20);
    check("R3 glitch rejected", count, 32'hFFFF_FFFF);
    set_ab(1'b1, 1'b1, 20);
    check("R3 stable change accepted", count, 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule